// File: doc/BRIEF.md
# Serial Memory Read Sequencer with CRC

This block sits between a host-side bit engine and a 128-byte read-only store arranged as four pages of 32 bytes. The bit engine hands it whole received bytes and asks it for the next byte to send. The engine shifts every byte on the wire least significant bit first, so this block deals only in whole bytes. A read starts with a command byte and a 16-bit start address, low byte first. The block first answers with a CRC over those three bytes, then streams memory bytes. It supports two read commands that differ only in where CRC bytes are inserted into the stream.

In page mode (command C3h) a CRC byte follows the last byte of every page, covering the bytes sent from that page. Streaming then resumes at the start of the next page. In field mode (command F0h) one CRC follows the last memory byte, covering every byte sent since the start address. After the closing CRC of either mode, every further byte reads as FFh. A bus reset aborts a read at any point.

The memory port has one cycle of read latency. The sequencer fetches each byte ahead of time, so a host that keeps requesting gets one new byte every clock cycle.

Top module: `srs_read_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it is released with no command, `tx_rdy` is 0.
- R2: When `dev_sel` is high and the command byte C3h or F0h arrives, the next two received bytes are taken as the start address, low byte first. One cycle after the high byte, `tx_rdy` is 1 and `tx_byte` holds the CRC of the command, low and high address bytes, in that order.
- R3: Every CRC byte uses the polynomial x^8+x^5+x^4+1 in reflected form (feedback constant 8Ch). Each byte is shifted in bit 0 first, starting from 00h.
- R4: In field mode, after the header CRC, the bytes sent are memory bytes from the start address up to address 127. Then comes one CRC over exactly those bytes, and then FFh.
- R5: In page mode, after the header CRC, memory bytes stream from the start address. A CRC byte follows each byte whose address has its low five bits all ones. That CRC covers only the bytes sent since the previous CRC, and streaming continues at the next address.
- R6: In page mode, every byte after the CRC of the page that ends at address 127 is FFh.
- R7: Once FFh fill has begun, every byte read is FFh until a bus reset, whatever is received meanwhile.
- R8: A high `bus_rst` at a clock edge aborts any read: `tx_rdy` is 0 in the next cycle, and the next received byte is treated as a command.
- R9: A byte received while `dev_sel` is low and no read is in progress is ignored. The byte that follows it is still treated as a command.
- R10: A command byte other than C3h or F0h makes the block ignore every byte until a bus reset, with `tx_rdy` held at 0.
- R11: A start address of 128 or more reads no memory bytes. In field mode the byte after the header CRC is 00h, then FFh fill follows. In page mode FFh fill follows the header CRC at once.
- R12: `tx_req` is acted on only while `tx_rdy` is 1. Each acted-on request moves to the next byte, and `tx_rdy` stays 1, so a request held high yields one byte per cycle.
- R13: Bytes received after the address, while a read is streaming, do not change the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset seen on the serial link, synchronous |
| dev_sel | input | 1 | Device has been selected, so commands may be accepted |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Host has taken `tx_byte` and wants the next one |
| tx_rdy | output | 1 | `tx_byte` holds a byte to send |
| tx_byte | output | 8 | Byte to send |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | MEM_AW (7) | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
A wrong cursor shows at once as a wrong data byte on the next read. A prefetch mis-timed by one cycle shows as the previous byte, or as the bench memory's garbage value, in a back-to-back burst. A fault in the CRC accumulator stays hidden until the next CRC byte, which can be up to 32 bytes later in page mode and 128 bytes later in field mode. For that reason the table vectors read whole pages and the whole field, and include starts near page ends and past the end of memory. Phase errors after end of memory show as a non-FFh byte or as `tx_rdy` dropping while the host holds `tx_req`.

// File: rtl/srs_pkg.sv
// Shared constants, phase encoding and the CRC byte step for the
// serial read sequencer. Assumes 8-bit bytes on every interface.
package srs_pkg;

    localparam logic [7:0] CMD_PAGE_CRC  = 8'hC3;
    localparam logic [7:0] CMD_FIELD_CRC = 8'hF0;
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
    localparam logic [7:0] FILL_BYTE     = 8'hFF;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR_LO,
        PH_ADDR_HI,
        PH_HDR,
        PH_DATA,
        PH_PCRC,
        PH_FCRC,
        PH_FILL,
        PH_HALT
    } phase_t;

    // One byte through the reflected CRC, bit 0 of the data first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = (c >> 1) ^ (fb ? CRC_POLY_REFL : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/srs_crc_acc.sv
// CRC accumulator. Holds the running CRC; on an update it folds one byte
// into either the held value or zero (seed). A clear forces zero.
// Assumes clear and update are never requested in the same cycle.
module srs_crc_acc
    import srs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic       seed,
    input  logic [7:0] din,
    output logic [7:0] crc_q
);

    // Running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= 8'h00;
        end else if (upd) begin
            crc_q <= crc8_step(seed ? 8'h00 : crc_q, din);
        end
    end

    AST_CRC_SEED_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && seed && !clr) |=> (crc_q == crc8_step(8'h00, $past(din)))); // R3

endmodule

// File: rtl/srs_prefetch.sv
// Memory read prefetcher. Passes read requests to the memory port and
// captures the returned byte one cycle later into a holding register.
// nxt_byte is the most recently fetched byte, valid from the cycle after
// the request. Assumes a synchronous memory with exactly one cycle of latency.
module srs_prefetch #(
    parameter int MEM_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [MEM_AW-1:0] issue_addr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        nxt_byte
);

    logic       rd_pend;
    logic [7:0] hold_q;

    // Request goes straight to the memory port.
    always_comb begin
        mem_rd_en = issue;
        mem_addr  = issue_addr;
    end

    // Track an outstanding read and keep its data once it returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            hold_q  <= 8'h00;
        end else begin
            rd_pend <= issue;
            if (rd_pend) begin
                hold_q <= mem_rdata;
            end
        end
    end

    // Freshest fetched byte: the live memory output in the return cycle.
    always_comb begin
        nxt_byte = rd_pend ? mem_rdata : hold_q;
    end

    AST_PF_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pend) |=> $stable(hold_q)); // R12

endmodule

// File: rtl/srs_stream_ctl.sv
// Read sequence controller. Decodes the command, captures the start
// address, and walks the output stream: header CRC, data bytes, page or
// field CRC, then FFh fill. It drives the CRC accumulator and the prefetcher.
// Assumes tx_byte is taken by the host only while tx_rdy is high, and that
// the next data byte is already held by the prefetcher when it is needed.
module srs_stream_ctl
    import srs_pkg::*;
#(
    parameter int MEM_AW  = 7,
    parameter int PAGE_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              dev_sel,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_rdy,
    output logic [7:0]        tx_byte,
    input  logic [7:0]        nxt_byte,
    input  logic [7:0]        crc_q,
    output logic              rd_issue,
    output logic [MEM_AW-1:0] rd_addr,
    output logic              crc_clr,
    output logic              crc_upd,
    output logic              crc_seed,
    output logic [7:0]        crc_din
);

    phase_t             phase;
    logic               page_mode;
    logic               beyond;
    logic [7:0]         addr_lo;
    logic [MEM_AW-1:0]  cur;
    logic [7:0]         dat_q;

    logic               accept;
    logic               at_page_end;
    logic               at_mem_end;
    logic [15:0]        start_full;
    logic               start_ok;
    logic               cmd_known;
    logic               go_data;
    logic [MEM_AW-1:0]  go_addr;

    // Output byte and ready, chosen by the phase.
    always_comb begin
        tx_rdy = 1'b0;
        tx_byte = 8'h00;
        case (phase)
            PH_HDR, PH_PCRC, PH_FCRC: begin
                tx_rdy = 1'b1;
                tx_byte = crc_q;
            end
            PH_DATA: begin
                tx_rdy = 1'b1;
                tx_byte = dat_q;
            end
            PH_FILL: begin
                tx_rdy = 1'b1;
                tx_byte = FILL_BYTE;
            end
            default: begin
                tx_rdy = 1'b0;
                tx_byte = 8'h00;
            end
        endcase
    end

    // Conditions derived from the current position and inputs.
    always_comb begin
        accept      = tx_rdy && tx_req && !bus_rst;
        at_page_end = &cur[PAGE_AW-1:0];
        at_mem_end  = &cur;
        start_full  = {rx_byte, addr_lo};
        start_ok    = (start_full >> MEM_AW) == 16'd0;
        cmd_known   = (rx_byte == CMD_PAGE_CRC) || (rx_byte == CMD_FIELD_CRC);
    end

    // Decide whether the byte taken now is followed by a data byte, and which.
    always_comb begin
        go_data = 1'b0;
        go_addr = cur;
        if (accept) begin
            case (phase)
                PH_HDR: begin
                    go_data = !beyond;
                    go_addr = cur;
                end
                PH_DATA: begin
                    go_data = page_mode ? !at_page_end : !at_mem_end;
                    go_addr = cur + 1'b1;
                end
                PH_PCRC: begin
                    go_data = !at_mem_end;
                    go_addr = cur + 1'b1;
                end
                default: begin
                    go_data = 1'b0;
                    go_addr = cur;
                end
            endcase
        end
    end

    // Prefetch request: the start byte, or the byte after the one presented.
    always_comb begin
        if (phase == PH_ADDR_HI) begin
            rd_issue = rx_valid && start_ok && !bus_rst;
            rd_addr  = start_full[MEM_AW-1:0];
        end else begin
            rd_issue = go_data && !(&go_addr);
            rd_addr  = go_addr + 1'b1;
        end
    end

    // CRC accumulator control for header bytes and streamed data.
    always_comb begin
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        crc_seed = 1'b0;
        crc_din  = rx_byte;
        if (!bus_rst) begin
            case (phase)
                PH_IDLE: begin
                    crc_upd  = rx_valid && dev_sel && cmd_known;
                    crc_seed = 1'b1;
                end
                PH_ADDR_LO, PH_ADDR_HI: begin
                    crc_upd = rx_valid;
                end
                PH_HDR, PH_DATA, PH_PCRC: begin
                    crc_upd  = go_data;
                    crc_seed = (phase != PH_DATA);
                    crc_din  = nxt_byte;
                    crc_clr  = (phase == PH_HDR) && accept && beyond && !page_mode;
                end
                default: begin
                    crc_upd = 1'b0;
                end
            endcase
        end
    end

    // Phase register and stream position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            page_mode <= 1'b0;
            beyond    <= 1'b0;
            addr_lo   <= 8'h00;
            cur       <= '0;
            dat_q     <= 8'h00;
        end else if (bus_rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (rx_valid && dev_sel) begin
                        page_mode <= (rx_byte == CMD_PAGE_CRC);
                        phase     <= cmd_known ? PH_ADDR_LO : PH_HALT;
                    end
                end
                PH_ADDR_LO: begin
                    if (rx_valid) begin
                        addr_lo <= rx_byte;
                        phase   <= PH_ADDR_HI;
                    end
                end
                PH_ADDR_HI: begin
                    if (rx_valid) begin
                        cur    <= start_full[MEM_AW-1:0];
                        beyond <= !start_ok;
                        phase  <= PH_HDR;
                    end
                end
                PH_HDR: begin
                    if (go_data) begin
                        dat_q <= nxt_byte;
                        cur   <= go_addr;
                        phase <= PH_DATA;
                    end else if (accept) begin
                        phase <= page_mode ? PH_FILL : PH_FCRC;
                    end
                end
                PH_DATA: begin
                    if (go_data) begin
                        dat_q <= nxt_byte;
                        cur   <= go_addr;
                    end else if (accept) begin
                        phase <= page_mode ? PH_PCRC : PH_FCRC;
                    end
                end
                PH_PCRC: begin
                    if (go_data) begin
                        dat_q <= nxt_byte;
                        cur   <= go_addr;
                        phase <= PH_DATA;
                    end else if (accept) begin
                        phase <= PH_FILL;
                    end
                end
                PH_FCRC: begin
                    if (accept) begin
                        phase <= PH_FILL;
                    end
                end
                default: begin
                    phase <= phase;
                end
            endcase
        end
    end

    AST_BUS_RST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !tx_rdy); // R8

    AST_UNSELECTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !dev_sel) |=> (phase == PH_IDLE)); // R9

    AST_FILL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL && !bus_rst) |=> (tx_rdy && tx_byte == FILL_BYTE)); // R7

    AST_PAGE_CRC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PCRC) |-> (page_mode && (&cur[PAGE_AW-1:0]))); // R5

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && !bus_rst) |=> tx_rdy); // R12

    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HALT && !bus_rst) |=> (phase == PH_HALT && !tx_rdy)); // R10

endmodule

// File: rtl/srs_read_seq.sv
// Top of the serial memory read sequencer. Connects the controller, the
// CRC accumulator and the memory prefetcher. Assumes a one-cycle-latency
// synchronous read memory of 2**MEM_AW bytes with pages of 2**PAGE_AW bytes.
module srs_read_seq #(
    parameter int MEM_AW  = 7,
    parameter int PAGE_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              dev_sel,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_rdy,
    output logic [7:0]        tx_byte,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    logic              rd_issue;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        nxt_byte;
    logic [7:0]        crc_q;
    logic              crc_clr;
    logic              crc_upd;
    logic              crc_seed;
    logic [7:0]        crc_din;

    srs_stream_ctl #(
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .dev_sel  (dev_sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_req   (tx_req),
        .tx_rdy   (tx_rdy),
        .tx_byte  (tx_byte),
        .nxt_byte (nxt_byte),
        .crc_q    (crc_q),
        .rd_issue (rd_issue),
        .rd_addr  (rd_addr),
        .crc_clr  (crc_clr),
        .crc_upd  (crc_upd),
        .crc_seed (crc_seed),
        .crc_din  (crc_din)
    );

    srs_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .seed  (crc_seed),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    srs_prefetch #(
        .MEM_AW (MEM_AW)
    ) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (rd_issue),
        .issue_addr (rd_addr),
        .mem_rdata  (mem_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .nxt_byte   (nxt_byte)
    );

    AST_RESET_NOT_READY: assert property (@(posedge clk)
        (!rst_n) |=> !tx_rdy); // R1

endmodule

// File: tb/srs_read_seq_tb.sv
module srs_read_seq_tb;

    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rst = 1'b0;
    logic          dev_sel = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          tx_req = 1'b0;
    logic          tx_rdy;
    logic [7:0]    tx_byte;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q [0:199];
    int         exp_n;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] nread;
        logic       gap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hF0, 8'h00, 8'h00, 8'd0,  1'b0},
        '{8'hC3, 8'h00, 8'h00, 8'd0,  1'b1},
        '{8'hC3, 8'h1E, 8'h00, 8'd0,  1'b0},
        '{8'hF0, 8'h7E, 8'h00, 8'd0,  1'b1},
        '{8'hF0, 8'h80, 8'h00, 8'd0,  1'b0},
        '{8'hC3, 8'h00, 8'h01, 8'd0,  1'b1},
        '{8'hC3, 8'h7F, 8'h00, 8'd0,  1'b0},
        '{8'hF0, 8'h45, 8'h00, 8'd10, 1'b1}
    };

    srs_read_seq #(.MEM_AW(AW), .PAGE_AW(5)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (bus_rst),
        .dev_sel   (dev_sel),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .tx_rdy    (tx_rdy),
        .tx_byte   (tx_byte),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] memv(input int a);
        return 8'(a * 29 + 90);
    endfunction

    // R3: bit-serial model of the reflected x^8+x^5+x^4+1 register
    function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c = {fb, c[7:1]};
            c[3] = c[3] ^ fb;
            c[2] = c[2] ^ fb;
        end
        return c;
    endfunction

    // Memory with one cycle of latency; garbage when not read
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= memv(int'(mem_addr));
        else           mem_rdata <= 8'hEE;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b);
        exp_q[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_expect(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] c;
        int start;
        exp_n = 0;
        push(ref_crc(ref_crc(ref_crc(8'h00, cmd), lo), hi));
        start = int'({hi, lo});
        c = 8'h00;
        if (cmd == 8'hF0) begin
            for (int a = start; a < 128; a++) begin
                push(memv(a));
                c = ref_crc(c, memv(a));
            end
            push(c);
        end else begin
            for (int a = start; a < 128; a++) begin
                push(memv(a));
                c = ref_crc(c, memv(a));
                if (a % 32 == 31) begin
                    push(c);
                    c = 8'h00;
                end
            end
        end
        repeat (4) push(8'hFF);
    endtask

    function automatic string tag_for(input logic [7:0] cmd, input int start, input int k);
        if (k == 0) return "R2 R3";
        if (start >= 128) return "R11";
        if (k >= exp_n - 4) return (cmd == 8'hC3) ? "R6 R7" : "R4 R7";
        return (cmd == 8'hC3) ? "R5" : "R4";
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic sel);
        dev_sel = sel;
        rx_byte = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_bus_rst();
        tx_req = 1'b0;
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, output int waited);
        waited = 0;
        while (!tx_rdy && waited < 40) begin
            tx_req = 1'b0;
            @(negedge clk);
            waited++;
        end
        b = tx_byte;
        tx_req = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int w;
        int bubbles;
        int nrd;
        int start;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_rdy == 1'b0, "R1 during reset", int'(tx_rdy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_rdy == 1'b0, "R1 after release", int'(tx_rdy), 0);

        // Table of read sequences
        for (int v = 0; v < NV; v++) begin
            pulse_bus_rst();
            build_expect(VECS[v].cmd, VECS[v].lo, VECS[v].hi);
            start = int'({VECS[v].hi, VECS[v].lo});
            nrd = (VECS[v].nread == 8'd0) ? exp_n : int'(VECS[v].nread);
            send_byte(VECS[v].cmd, 1'b1);
            send_byte(VECS[v].lo, 1'b1);
            send_byte(VECS[v].hi, 1'b1);
            bubbles = 0;
            for (int k = 0; k < nrd; k++) begin
                get_byte(b, w);
                if (w != 0) bubbles++;
                if (VECS[v].gap) begin
                    tx_req = 1'b0;
                    @(negedge clk);
                end
                chk(b == exp_q[k], $sformatf("%s vec %0d byte %0d", tag_for(VECS[v].cmd, start, k), v, k),
                    int'(b), int'(exp_q[k]));
            end
            tx_req = 1'b0;
            if (!VECS[v].gap) chk(bubbles == 0, $sformatf("R12 burst bubbles vec %0d", v), bubbles, 0);
        end

        // R8: bus reset mid-stream, then a fresh command
        pulse_bus_rst();
        send_byte(8'hC3, 1'b1);
        send_byte(8'h05, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        get_byte(b, w);
        tx_req = 1'b0;
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk(tx_rdy == 1'b0, "R8 ready after bus reset", int'(tx_rdy), 0);
        build_expect(8'hF0, 8'h10, 8'h00);
        send_byte(8'hF0, 1'b1);
        send_byte(8'h10, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        chk(b == exp_q[0], "R8 header after abort", int'(b), int'(exp_q[0]));
        get_byte(b, w);
        tx_req = 1'b0;
        chk(b == exp_q[1], "R8 first data after abort", int'(b), int'(exp_q[1]));

        // R13: received bytes during streaming are ignored
        pulse_bus_rst();
        build_expect(8'hC3, 8'h00, 8'h00);
        send_byte(8'hC3, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        for (int k = 0; k < 4; k++) get_byte(b, w);
        tx_req = 1'b0;
        send_byte(8'hF0, 1'b1);
        send_byte(8'h40, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        tx_req = 1'b0;
        chk(b == exp_q[4], "R13 stream continues", int'(b), int'(exp_q[4]));

        // R9: unselected command is ignored, next byte is a command
        pulse_bus_rst();
        send_byte(8'hF0, 1'b0);
        chk(tx_rdy == 1'b0, "R9 no output when unselected", int'(tx_rdy), 0);
        build_expect(8'hC3, 8'h00, 8'h00);
        send_byte(8'hC3, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        tx_req = 1'b0;
        chk(b == exp_q[0], "R9 header of selected command", int'(b), int'(exp_q[0]));

        // R10: unsupported command silences the block until bus reset
        pulse_bus_rst();
        send_byte(8'h55, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'hC3, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        repeat (3) @(negedge clk);
        chk(tx_rdy == 1'b0, "R10 silent after unknown command", int'(tx_rdy), 0);

        // R12: requests with nothing pending do not skip bytes
        pulse_bus_rst();
        tx_req = 1'b1;
        repeat (3) @(negedge clk);
        tx_req = 1'b0;
        build_expect(8'hF0, 8'h00, 8'h00);
        send_byte(8'hF0, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        chk(b == exp_q[0], "R12 header not skipped", int'(b), int'(exp_q[0]));
        get_byte(b, w);
        tx_req = 1'b0;
        chk(b == exp_q[1], "R12 first data not skipped", int'(b), int'(exp_q[1]));

        // R7: fill persists despite received bytes; bus reset ends it
        pulse_bus_rst();
        send_byte(8'hC3, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h02, 1'b1);
        get_byte(b, w);
        tx_req = 1'b0;
        send_byte(8'hF0, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        tx_req = 1'b0;
        chk(b == 8'hFF, "R7 fill after received bytes", int'(b), 8'hFF);
        pulse_bus_rst();
        chk(tx_rdy == 1'b0, "R7 fill ends at bus reset", int'(tx_rdy), 0);

        // R1: synchronous reset mid-stream
        send_byte(8'hF0, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h00, 1'b1);
        get_byte(b, w);
        tx_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_rdy == 1'b0, "R1 reset mid-stream", int'(tx_rdy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule